// File: doc/BRIEF.md
# System Control Port Register

This block is a single 8-bit control register on a byte-wide I/O bus, decoded at one port address (0x92). Software writes a byte to it and reads the same byte back. Two bits of the stored byte act on the system. Bit 1 drives the address-line-20 gate output continuously. A change of bit 0 from 0 to 1 asks the system reset controller for a reset, through a one-clock pulse.

There are two resets. Power-on reset clears the whole register. Device reset clears only bit 0. The gate setting and the upper bits therefore survive a device reset, and the next write of a 1 to bit 0 can request a reset again.

Top module: `sys_ctl_port`

## Requirements
- R1: Only address 0x0092 is decoded. A write to any other address leaves the stored byte, the gate output and the pulse output unchanged. A read of any other address returns 0x00.
- R2: A write strobe at the decoded address stores all 8 data bits at the clock edge. While the read strobe is high at the decoded address, the read data shows the stored byte in that same cycle. At all other times the read data is 0x00.
- R3: The gate output always equals bit 1 of the stored byte. It takes its new value at the same clock edge that stores the write.
- R4: A write with data bit 0 = 1, when the stored bit 0 is 0, raises the reset request output for the one cycle that follows the storing edge.
- R5: A write with data bit 0 = 1 when the stored bit 0 is already 1 raises no reset request. Neither does a write with data bit 0 = 0.
- R6: A device reset clears stored bit 0 and keeps bits 7..1, so the gate output does not change. A later write of 1 to bit 0 requests a reset again.
- R7: Power-on reset sets the stored byte to 0x00 and holds the reset request low. It takes priority over device reset and over a write in the same cycle.
- R8: When a write and a device reset occur in the same cycle, bits 7..1 take the written data, bit 0 becomes 0, and no reset request is raised.
- R9: The reset request output is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| dev_rst | input | 1 | Synchronous active-high device reset; clears bit 0 only |
| bus_addr | input | 16 | I/O port address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the cycle of a decoded read |
| addr20_gate | output | 1 | Address-line-20 gate enable (stored bit 1) |
| sys_rst_pulse | output | 1 | One-cycle system reset request |

## Verification
The bench repeats a write of 1 to bit 0. A design that detects the level of bit 0 instead of its edge raises a second reset request here. The bench applies a device reset while the gate bit is set. A design that clears the whole register drops the gate. The bench also drives a write and a device reset in the same cycle, and a power-on reset together with a device reset. Here a wrong priority shows up as a stray pulse or as stale bits. Near misses of the address (0x0093 and 0x0192) catch a decoder that compares too few bits.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int unsigned SCP_DATA_W = 8;
  localparam int unsigned SCP_RQ_BIT = 0;  // bit whose rising edge requests a reset
  localparam int unsigned SCP_GT_BIT = 1;  // bit driving the address-20 gate
  typedef struct packed {
    logic wr_hit;
    logic rd_hit;
  } scp_req_t;
endpackage

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h92
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output scp_req_t          req
);
  logic match;
  assign match      = (addr == PORT_ADDR);
  assign req.wr_hit = wr & match;
  assign req.rd_hit = rd & match;
endmodule

// File: rtl/scp_store.sv
module scp_store #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLR_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_en) nxt = wdata;
    if (dev_rst) nxt[CLR_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  AST_POR_CLEAR: assert property (@(posedge clk) rst |=> (q == '0)); // R7
  AST_DEVRST_KEEP: assert property (@(posedge clk) disable iff (rst)
    ($past(dev_rst) && !$past(wr_en) && !$past(rst)) |->
      (q[DATA_W-1:1] == $past(q[DATA_W-1:1])) && !q[CLR_BIT]); // R6
  AST_WR_DEVRST: assert property (@(posedge clk) disable iff (rst)
    ($past(dev_rst) && $past(wr_en) && !$past(rst)) |->
      (q[DATA_W-1:1] == $past(wdata[DATA_W-1:1])) && !q[CLR_BIT]); // R8
endmodule

// File: rtl/scp_edge.sv
module scp_edge (
  input  logic clk,
  input  logic rst,
  input  logic dev_rst,
  input  logic wr_en,
  input  logic new_bit,
  input  logic cur_bit,
  output logic pulse
);
  logic fire;
  assign fire = wr_en & new_bit & ~cur_bit & ~dev_rst;

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= fire;
  end

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    pulse |-> ($past(wr_en) && $past(new_bit) && !$past(cur_bit) && !$past(dev_rst))); // R4
  AST_NO_REARM: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cur_bit) |=> !pulse); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse); // R9
endmodule

// File: rtl/sys_ctl_port.sv
module sys_ctl_port
  import scp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h92,
  parameter int unsigned DATA_W    = SCP_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              addr20_gate,
  output logic              sys_rst_pulse
);
  scp_req_t          req;
  logic [DATA_W-1:0] stored;

  scp_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .req(req)
  );

  scp_store #(.DATA_W(DATA_W), .CLR_BIT(SCP_RQ_BIT)) u_reg (
    .clk(clk), .rst(rst), .dev_rst(dev_rst), .wr_en(req.wr_hit),
    .wdata(bus_wdata), .q(stored)
  );

  scp_edge u_edge (
    .clk(clk), .rst(rst), .dev_rst(dev_rst), .wr_en(req.wr_hit),
    .new_bit(bus_wdata[SCP_RQ_BIT]), .cur_bit(stored[SCP_RQ_BIT]),
    .pulse(sys_rst_pulse)
  );

  assign bus_rdata   = req.rd_hit ? stored : '0;
  assign addr20_gate = stored[SCP_GT_BIT];

  AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_wr) && ($past(bus_addr) != PORT_ADDR) && !$past(dev_rst) && !$past(rst))
      |-> ($stable(addr20_gate) && !sys_rst_pulse)); // R1
  AST_GATE_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == PORT_ADDR) |-> (bus_rdata[SCP_GT_BIT] == addr20_gate)); // R3
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |-> (bus_rdata == '0)); // R2
endmodule

// File: tb/sys_ctl_port_test.sv
`timescale 1ns/1ps
module sys_ctl_port_test;
  logic        clk = 1'b0;
  logic        rst, dev_rst, bus_wr, bus_rd;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        addr20_gate, sys_rst_pulse;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sys_ctl_port uut (
    .clk(clk), .rst(rst), .dev_rst(dev_rst), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .addr20_gate(addr20_gate),
    .sys_rst_pulse(sys_rst_pulse)
  );

  // {is_write, addr, data, expected, req}; for writes expected = {gate, pulse}
  localparam int NV = 14;
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 16'h0092, 8'h02, 8'h02, 4'd3},  // R3 gate rises, no pulse
    {1'b0, 16'h0092, 8'h00, 8'h02, 4'd2},  // R2 read back
    {1'b1, 16'h0092, 8'h03, 8'h03, 4'd4},  // R4 bit0 rises
    {1'b1, 16'h0092, 8'h03, 8'h02, 4'd5},  // R5 bit0 already set
    {1'b1, 16'h0093, 8'h00, 8'h02, 4'd1},  // R1 near-miss write
    {1'b0, 16'h0093, 8'h00, 8'h00, 4'd1},  // R1 near-miss read
    {1'b0, 16'h0092, 8'h00, 8'h03, 4'd1},  // R1 value kept
    {1'b1, 16'h0092, 8'hA4, 8'h00, 4'd3},  // R3 gate falls
    {1'b0, 16'h0092, 8'h00, 8'hA4, 4'd2},  // R2 full byte
    {1'b1, 16'h0192, 8'hFF, 8'h00, 4'd1},  // R1 high-byte miss
    {1'b1, 16'h0092, 8'h5D, 8'h01, 4'd4},  // R4 rise again
    {1'b0, 16'h0092, 8'h00, 8'h5D, 4'd2},  // R2
    {1'b1, 16'h0092, 8'h5C, 8'h00, 4'd5},  // R5 bit0 cleared, no pulse
    {1'b1, 16'h0092, 8'h5F, 8'h03, 4'd4}   // R4
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_cycle(input logic [15:0] a, input logic [7:0] d, input logic dr);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; dev_rst = dr;
    @(negedge clk);
    bus_wr = 1'b0; dev_rst = 1'b0;
  endtask

  task automatic rd_val(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    logic [7:0] v;
    rst = 1'b1; dev_rst = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd_val(16'h0092, v);
    chk("R7 por value", v, 8'h00);
    chk("R7 por outputs", {6'b0, addr20_gate, sys_rst_pulse}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][36]) begin
        wr_cycle(VEC[i][35:20], VEC[i][19:12], 1'b0);
        chk($sformatf("R%0d vec %0d", VEC[i][3:0], i),
            {6'b0, addr20_gate, sys_rst_pulse}, VEC[i][11:4]);
      end else begin
        rd_val(VEC[i][35:20], v);
        chk($sformatf("R%0d vec %0d", VEC[i][3:0], i), v, VEC[i][11:4]);
      end
    end

    // R2: no read strobe gives zero
    @(negedge clk); bus_addr = 16'h0092; #1;
    chk("R2 idle read", bus_rdata, 8'h00);

    // R9: pulse lasts one cycle (stored is 5F now; clear bit0 then rise)
    wr_cycle(16'h0092, 8'h5E, 1'b0);
    wr_cycle(16'h0092, 8'h5F, 1'b0);
    chk("R4 rise pulse", {7'b0, sys_rst_pulse}, 8'h01);
    @(negedge clk);
    chk("R9 pulse single", {7'b0, sys_rst_pulse}, 8'h00);

    // R6: device reset keeps bits 7..1
    @(negedge clk); dev_rst = 1'b1;
    @(negedge clk); dev_rst = 1'b0;
    chk("R6 gate kept", {7'b0, addr20_gate}, 8'h01);
    chk("R6 no pulse", {7'b0, sys_rst_pulse}, 8'h00);
    rd_val(16'h0092, v);
    chk("R6 value", v, 8'h5E);
    wr_cycle(16'h0092, 8'h5F, 1'b0);
    chk("R6 rearmed pulse", {7'b0, sys_rst_pulse}, 8'h01);

    // R8: write with device reset in same cycle
    wr_cycle(16'h0092, 8'h27, 1'b1);
    chk("R8 no pulse", {7'b0, sys_rst_pulse}, 8'h00);
    rd_val(16'h0092, v);
    chk("R8 value", v, 8'h26);
    wr_cycle(16'h0092, 8'h27, 1'b0);
    chk("R8 later rise pulses", {7'b0, sys_rst_pulse}, 8'h01);

    // R7: power-on reset with device reset and a rising write
    wr_cycle(16'h0092, 8'hC6, 1'b0);
    @(negedge clk);
    rst = 1'b1; dev_rst = 1'b1; bus_wr = 1'b1; bus_addr = 16'h0092; bus_wdata = 8'h03;
    @(negedge clk);
    rst = 1'b0; dev_rst = 1'b0; bus_wr = 1'b0;
    chk("R7 priority outputs", {6'b0, addr20_gate, sys_rst_pulse}, 8'h00);
    rd_val(16'h0092, v);
    chk("R7 priority value", v, 8'h00);

    done = 1'b1;
    summary();
  end
endmodule